// File: doc/BRIEF.md
# Pipeline Hazard Controller with Data-Cache Freeze

This block is the hazard controller of a five-stage in-order integer pipeline whose stages are fetch, decode, execute, memory and writeback. It looks at the register numbers held in the decode and execute stages, at the destination registers and write enables of the later stages, at whether the execute instruction is a load, at the branch outcome resolved in execute, and at a stall request raised by the data cache. From these it computes the operand-bypass selects for the execute-stage ALU, one hold signal for each pipeline stage, and the bubble-insertion signals for the decode and execute pipeline registers.

The controller is purely combinational and has no clock, reset or stored state. A data-cache miss holds every stage at once, and while that hold is active no pipeline register is cleared, so no instruction is lost while memory is busy. A load followed at once by a consumer holds fetch and decode for one cycle and turns the execute slot into a bubble. A taken branch clears the two younger instructions.

Top module: `pipe_hazard_ctrl`

## Requirements
- R1: Each ALU operand gets its own 2-bit bypass select: operand A is compared using `ex_rs1_i`, operand B using `ex_rs2_i`. The select is 2'b10 for the memory-stage ALU result, 2'b01 for the writeback result and 2'b00 for the register-file value. The value 2'b11 never appears.
- R2: When both the memory stage and the writeback stage would supply the same source register, the select is 2'b10, because the memory stage holds the newer result.
- R3: A stage supplies a bypass value only when its write enable is 1 and the execute source register is not register 0. Otherwise the select ignores that stage.
- R4: A load-use hazard exists when bit 0 of `ex_res_src_i` is 1 (the execute instruction is a load) and `dec_rs1_i` or `dec_rs2_i` equals `ex_rd_i`. When bit 0 is 0, a register match causes no hazard.
- R5: `stall_f_o` and `stall_d_o` are 1 when there is a load-use hazard or when `dcache_stall_i` is 1.
- R6: `stall_e_o`, `stall_m_o` and `stall_w_o` follow `dcache_stall_i` alone. A load-use hazard does not set them.
- R7: When `dcache_stall_i` is 0, `flush_d_o` equals `ex_branch_taken_i`, and `flush_e_o` equals the load-use hazard OR `ex_branch_taken_i`.
- R8: When `dcache_stall_i` is 1, `flush_d_o` and `flush_e_o` are both 0, even if a branch is taken or a load-use hazard exists.
- R9: Every output depends only on the present inputs. No output depends on earlier input values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dec_rs1_i | input | 5 | First source register of the decode instruction |
| dec_rs2_i | input | 5 | Second source register of the decode instruction |
| ex_rs1_i | input | 5 | First source register of the execute instruction |
| ex_rs2_i | input | 5 | Second source register of the execute instruction |
| ex_rd_i | input | 5 | Destination register of the execute instruction |
| ex_res_src_i | input | 2 | Result-source code of the execute instruction; bit 0 set marks a load |
| mem_rd_i | input | 5 | Destination register of the memory-stage instruction |
| mem_wr_en_i | input | 1 | The memory-stage instruction writes a register |
| wb_rd_i | input | 5 | Destination register of the writeback instruction |
| wb_wr_en_i | input | 1 | The writeback instruction writes a register |
| ex_branch_taken_i | input | 1 | The branch or jump in execute is taken |
| dcache_stall_i | input | 1 | The data cache requests that the pipeline hold |
| fwd_a_o | output | 2 | Bypass select for ALU operand A |
| fwd_b_o | output | 2 | Bypass select for ALU operand B |
| stall_f_o | output | 1 | Hold the fetch stage / program counter |
| stall_d_o | output | 1 | Hold the decode pipeline register |
| stall_e_o | output | 1 | Hold the execute pipeline register |
| stall_m_o | output | 1 | Hold the memory pipeline register |
| stall_w_o | output | 1 | Hold the writeback pipeline register |
| flush_d_o | output | 1 | Clear the decode pipeline register |
| flush_e_o | output | 1 | Clear the execute pipeline register |

## Verification
The bench drives cases where the memory and writeback stages match the same source register. A design with the priority reversed would select the older writeback value and return a stale operand. It drives a match on register 0 with the write enable set, and a match with the write enable clear. A design that got either wrong would bypass a value that must never be read. It raises a taken branch together with a cache stall, and a load-use hazard together with a cache stall. A design that let flushes through there would clear instructions that are only waiting for memory. It also drives a load-use hazard with no cache stall and checks that only fetch and decode hold, so a design that froze the later stages would lose the bubble.

// File: rtl/pipe_hazard_pkg.sv
package pipe_hazard_pkg;

    localparam int unsigned REG_W = 5;
    localparam int unsigned N_OPND = 2;
    localparam int unsigned N_STAGE = 5;

    typedef logic [REG_W-1:0] reg_idx_t;

    typedef enum logic [1:0] {
        BYP_REGFILE = 2'b00,
        BYP_WB      = 2'b01,
        BYP_MEM     = 2'b10
    } byp_sel_e;

    typedef struct packed {
        reg_idx_t rd;
        logic     wr_en;
    } producer_t;

    typedef struct packed {
        logic fetch;
        logic decode;
        logic execute;
        logic memory;
        logic writeback;
    } stage_hold_t;

    typedef struct packed {
        logic decode;
        logic execute;
    } stage_clear_t;

    // A later stage can supply a value for src only if it writes and src is not x0.
    function automatic logic supplies(input reg_idx_t src, input producer_t p);
        return p.wr_en && (src == p.rd) && (src != '0);
    endfunction

endpackage

// File: rtl/hz_bypass_sel.sv
module hz_bypass_sel
    import pipe_hazard_pkg::*;
(
    input  reg_idx_t  src_i,
    input  producer_t mem_i,
    input  producer_t wb_i,
    output byp_sel_e  sel_o
);
    logic from_mem;
    logic from_wb;

    assign from_mem = supplies(src_i, mem_i);
    assign from_wb  = supplies(src_i, wb_i);

    always_comb begin
        if (from_mem) begin
            sel_o = BYP_MEM;
        end else if (from_wb) begin
            sel_o = BYP_WB;
        end else begin
            sel_o = BYP_REGFILE;
        end
    end
endmodule

// File: rtl/hz_load_use.sv
module hz_load_use
    import pipe_hazard_pkg::*;
#(
    parameter int unsigned N_SRC = 2
) (
    input  reg_idx_t [N_SRC-1:0] dec_src_i,
    input  reg_idx_t             ex_rd_i,
    input  logic                 ex_is_load_i,
    output logic                 hazard_o
);
    logic [N_SRC-1:0] hit;

    for (genvar g = 0; g < N_SRC; g++) begin : g_cmp
        assign hit[g] = (dec_src_i[g] == ex_rd_i);
    end

    assign hazard_o = ex_is_load_i && (|hit);
endmodule

// File: rtl/hz_hold_clear.sv
module hz_hold_clear
    import pipe_hazard_pkg::*;
(
    input  logic         load_use_i,
    input  logic         branch_taken_i,
    input  logic         mem_wait_i,
    output stage_hold_t  hold_o,
    output stage_clear_t clear_o
);
    always_comb begin
        hold_o.fetch     = load_use_i | mem_wait_i;
        hold_o.decode    = load_use_i | mem_wait_i;
        hold_o.execute   = mem_wait_i;
        hold_o.memory    = mem_wait_i;
        hold_o.writeback = mem_wait_i;

        clear_o = '0;
        if (!mem_wait_i) begin
            clear_o.decode  = branch_taken_i;
            clear_o.execute = branch_taken_i | load_use_i;
        end
    end
endmodule

// File: rtl/pipe_hazard_ctrl.sv
module pipe_hazard_ctrl
    import pipe_hazard_pkg::*;
(
    input  logic [4:0] dec_rs1_i,
    input  logic [4:0] dec_rs2_i,
    input  logic [4:0] ex_rs1_i,
    input  logic [4:0] ex_rs2_i,
    input  logic [4:0] ex_rd_i,
    input  logic [1:0] ex_res_src_i,
    input  logic [4:0] mem_rd_i,
    input  logic       mem_wr_en_i,
    input  logic [4:0] wb_rd_i,
    input  logic       wb_wr_en_i,
    input  logic       ex_branch_taken_i,
    input  logic       dcache_stall_i,
    output logic [1:0] fwd_a_o,
    output logic [1:0] fwd_b_o,
    output logic       stall_f_o,
    output logic       stall_d_o,
    output logic       stall_e_o,
    output logic       stall_m_o,
    output logic       stall_w_o,
    output logic       flush_d_o,
    output logic       flush_e_o
);
    reg_idx_t [N_OPND-1:0] ex_src;
    reg_idx_t [N_OPND-1:0] dec_src;
    byp_sel_e [N_OPND-1:0] sel;
    producer_t             mem_p;
    producer_t             wb_p;
    logic                  load_use;
    stage_hold_t           hold;
    stage_clear_t          clear;

    assign ex_src  = {ex_rs2_i, ex_rs1_i};
    assign dec_src = {dec_rs2_i, dec_rs1_i};
    assign mem_p   = '{rd: mem_rd_i, wr_en: mem_wr_en_i};
    assign wb_p    = '{rd: wb_rd_i, wr_en: wb_wr_en_i};

    for (genvar g = 0; g < N_OPND; g++) begin : g_opnd
        hz_bypass_sel u_sel (
            .src_i (ex_src[g]),
            .mem_i (mem_p),
            .wb_i  (wb_p),
            .sel_o (sel[g])
        );
    end

    hz_load_use #(.N_SRC(N_OPND)) u_lu (
        .dec_src_i    (dec_src),
        .ex_rd_i      (ex_rd_i),
        .ex_is_load_i (ex_res_src_i[0]),
        .hazard_o     (load_use)
    );

    hz_hold_clear u_hc (
        .load_use_i     (load_use),
        .branch_taken_i (ex_branch_taken_i),
        .mem_wait_i     (dcache_stall_i),
        .hold_o         (hold),
        .clear_o        (clear)
    );

    assign fwd_a_o   = sel[0];
    assign fwd_b_o   = sel[1];
    assign stall_f_o = hold.fetch;
    assign stall_d_o = hold.decode;
    assign stall_e_o = hold.execute;
    assign stall_m_o = hold.memory;
    assign stall_w_o = hold.writeback;
    assign flush_d_o = clear.decode;
    assign flush_e_o = clear.execute;
endmodule

// File: rtl/pipe_hazard_ctrl_chk.sv
module pipe_hazard_ctrl_chk (
    input logic [4:0] ex_rs1_i,
    input logic [4:0] ex_rs2_i,
    input logic       mem_wr_en_i,
    input logic       wb_wr_en_i,
    input logic       dcache_stall_i,
    input logic [1:0] fwd_a_o,
    input logic [1:0] fwd_b_o,
    input logic       stall_f_o,
    input logic       stall_d_o,
    input logic       stall_e_o,
    input logic       stall_m_o,
    input logic       stall_w_o,
    input logic       flush_d_o,
    input logic       flush_e_o
);
    always_comb begin
        p_sel_legal_r1: assert (fwd_a_o != 2'b11 && fwd_b_o != 2'b11);
        p_zero_src_r3: assert (!((ex_rs1_i == 5'd0 && fwd_a_o != 2'b00) ||
                                 (ex_rs2_i == 5'd0 && fwd_b_o != 2'b00)));
        p_mem_wen_r3: assert (mem_wr_en_i || (fwd_a_o != 2'b10 && fwd_b_o != 2'b10));
        p_wb_wen_r3: assert (wb_wr_en_i || (fwd_a_o != 2'b01 && fwd_b_o != 2'b01));
        p_front_hold_r5: assert (!stall_e_o || (stall_f_o && stall_d_o));
        p_back_hold_r6: assert ((stall_e_o == stall_m_o) && (stall_m_o == stall_w_o));
        p_no_flush_wait_r8: assert (!dcache_stall_i || (!flush_d_o && !flush_e_o));
        p_flush_order_r7: assert (!flush_d_o || flush_e_o);
    end
endmodule

bind pipe_hazard_ctrl pipe_hazard_ctrl_chk u_chk (
    .ex_rs1_i       (ex_rs1_i),
    .ex_rs2_i       (ex_rs2_i),
    .mem_wr_en_i    (mem_wr_en_i),
    .wb_wr_en_i     (wb_wr_en_i),
    .dcache_stall_i (dcache_stall_i),
    .fwd_a_o        (fwd_a_o),
    .fwd_b_o        (fwd_b_o),
    .stall_f_o      (stall_f_o),
    .stall_d_o      (stall_d_o),
    .stall_e_o      (stall_e_o),
    .stall_m_o      (stall_m_o),
    .stall_w_o      (stall_w_o),
    .flush_d_o      (flush_d_o),
    .flush_e_o      (flush_e_o)
);

// File: tb/pipe_hazard_ctrl_tb.sv
`timescale 1ns/1ps
module pipe_hazard_ctrl_tb;
    logic clk = 1'b0;
    logic rst;
    always #10 clk = ~clk;

    logic [4:0] dec_rs1, dec_rs2, ex_rs1, ex_rs2, ex_rd, mem_rd, wb_rd;
    logic [1:0] ex_res_src;
    logic mem_we, wb_we, taken, cstall;
    logic [1:0] fa, fb;
    logic sf, sd, se, sm, sw, fd, fe;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    pipe_hazard_ctrl u_dut (
        .dec_rs1_i(dec_rs1), .dec_rs2_i(dec_rs2),
        .ex_rs1_i(ex_rs1), .ex_rs2_i(ex_rs2), .ex_rd_i(ex_rd),
        .ex_res_src_i(ex_res_src),
        .mem_rd_i(mem_rd), .mem_wr_en_i(mem_we),
        .wb_rd_i(wb_rd), .wb_wr_en_i(wb_we),
        .ex_branch_taken_i(taken), .dcache_stall_i(cstall),
        .fwd_a_o(fa), .fwd_b_o(fb),
        .stall_f_o(sf), .stall_d_o(sd), .stall_e_o(se), .stall_m_o(sm), .stall_w_o(sw),
        .flush_d_o(fd), .flush_e_o(fe)
    );

    task automatic idle();
        dec_rs1 = 0; dec_rs2 = 0; ex_rs1 = 0; ex_rs2 = 0; ex_rd = 0;
        ex_res_src = 0; mem_rd = 0; mem_we = 0; wb_rd = 0; wb_we = 0;
        taken = 0; cstall = 0;
    endtask

    task automatic settle();
        @(negedge clk);
        #2;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // holds packed as {f,d,e,m,w}; flushes as {d,e}
    function automatic logic [4:0] holds();
        return {sf, sd, se, sm, sw};
    endfunction

    task automatic t_reset_state();
        rst = 1'b1; idle(); settle();
        chk("R9 reset fwd", {fa, fb}, 4'b0000);
        chk("R9 reset holds", holds(), 5'b00000);
        chk("R9 reset flush", {fd, fe}, 2'b00);
        rst = 1'b0;
    endtask

    task automatic t_fwd_mem();
        idle(); ex_rs1 = 5'd7; ex_rs2 = 5'd9; mem_rd = 5'd7; mem_we = 1; settle();
        chk("R1 A from mem", fa, 2'b10);
        chk("R1 B register file", fb, 2'b00);
    endtask

    task automatic t_fwd_wb();
        idle(); ex_rs1 = 5'd4; ex_rs2 = 5'd3; wb_rd = 5'd3; wb_we = 1; settle();
        chk("R1 B from wb", fb, 2'b01);
        chk("R1 A register file", fa, 2'b00);
    endtask

    task automatic t_priority();
        idle(); ex_rs1 = 5'd12; ex_rs2 = 5'd12;
        mem_rd = 5'd12; mem_we = 1; wb_rd = 5'd12; wb_we = 1; settle();
        chk("R2 A mem over wb", fa, 2'b10);
        chk("R2 B mem over wb", fb, 2'b10);
        mem_rd = 5'd13; settle();
        chk("R2 A falls to wb", fa, 2'b01);
    endtask

    task automatic t_x0_and_wen();
        idle(); mem_rd = 5'd0; mem_we = 1; wb_rd = 5'd0; wb_we = 1; settle();
        chk("R3 x0 not bypassed", {fa, fb}, 4'b0000);
        idle(); ex_rs1 = 5'd20; ex_rs2 = 5'd21; mem_rd = 5'd20; wb_rd = 5'd21; settle();
        chk("R3 no write enable", {fa, fb}, 4'b0000);
    endtask

    task automatic t_load_use();
        idle(); ex_res_src = 2'b01; ex_rd = 5'd8; dec_rs1 = 5'd8; dec_rs2 = 5'd2; settle();
        chk("R4 R5 R6 load-use rs1 holds", holds(), 5'b11000);
        chk("R7 load-use flush", {fd, fe}, 2'b01);
        dec_rs1 = 5'd1; dec_rs2 = 5'd8; settle();
        chk("R4 load-use rs2", holds(), 5'b11000);
        dec_rs2 = 5'd9; settle();
        chk("R4 load no match", {holds(), fd, fe}, 7'b0);
        ex_res_src = 2'b10; dec_rs2 = 5'd8; settle();
        chk("R4 non-load match ignored", {holds(), fd, fe}, 7'b0);
    endtask

    task automatic t_branch();
        idle(); taken = 1; settle();
        chk("R7 branch flush", {fd, fe}, 2'b11);
        chk("R7 branch no hold", holds(), 5'b00000);
    endtask

    task automatic t_cache();
        idle(); cstall = 1; settle();
        chk("R5 R6 cache freezes all", holds(), 5'b11111);
        taken = 1; settle();
        chk("R8 branch flush masked", {fd, fe}, 2'b00);
        taken = 0; ex_res_src = 2'b01; ex_rd = 5'd5; dec_rs1 = 5'd5; settle();
        chk("R8 load-use flush masked", {fd, fe}, 2'b00);
        chk("R5 R6 hold under both", holds(), 5'b11111);
        cstall = 0; settle();
        chk("R9 release follows input", {holds(), fd, fe}, 7'b1100001);
    endtask

    initial begin
        t_reset_state();
        t_fwd_mem();
        t_fwd_wb();
        t_priority();
        t_x0_and_wen();
        t_load_use();
        t_branch();
        t_cache();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (10000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule